// File: doc/BRIEF.md
# Array-Sum Coprocessor with Translating Load Bridge

This block serves a scalar core as a coprocessor for one custom instruction. The core hands over a function code and two operands: the byte address of a word array and the number of 32-bit elements to add. The block checks the command, then fetches the elements through its own load bridge and returns the 32-bit sum. A command that fails the check returns a fixed error word in place of a sum.

The load bridge adds a base address, sampled when the command is accepted, to every CPU-side address. The result is the physical address it places on a request channel. The block does not know the memory's timing. Requests leave on a valid/ready channel that stands for the write side of a request FIFO, so a full FIFO stalls them. Read data comes back on a valid/ready channel that stands for the read side of a response FIFO, so an empty FIFO stalls the adder. Up to a parameterised number of loads may be in flight. Responses return in request order.

The core side has a valid/ready command port and a one-cycle done pulse that carries the result. Only one command is in progress at a time.

Top module: `acc_sum_unit`

## Requirements
- R1: For an accepted command with function code 0, a 4-byte aligned start address and a count n > 0, the result is the sum modulo 2^32 of the n data words returned for the requests. The result is presented on `result_o` while `done_o` is high.
- R2: A command whose function code is not 0 completes with result 0xFFFF_FFFE. `done_o` rises in the cycle after acceptance and no request is issued. This check takes precedence over the alignment check.
- R3: A command with function code 0 whose start address has bit 1 or bit 0 set completes with result 0xFFFF_FFFF. `done_o` rises in the cycle after acceptance and no request is issued.
- R4: A valid command with a count of 0 completes with result 0. `done_o` rises in the cycle after acceptance and no request is issued.
- R5: A valid command issues exactly n requests. Their addresses are base + start + 4*i for i = 0..n-1, in increasing order, where base is the value of `base_addr_i` in the acceptance cycle. Changes of `base_addr_i` after acceptance have no effect.
- R6: No more than MAX_OUT (default 4) requests are outstanding at any time. A stalled request keeps `req_valid_o` high and `req_addr_o` unchanged until it is taken. `rsp_ready_o` is high only while a request is outstanding.
- R7: `cmd_ready_o` is low from the cycle after acceptance through the cycle in which `done_o` is high. `done_o` is a one-cycle pulse. Commands issued back to back each return their own result, in issue order.
- R8: Asserting `rst_ni` low returns the block to idle at any time. Idle means `cmd_ready_o` high, and `done_o`, `req_valid_o` and `rsp_ready_o` low. A command issued after reset completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_addr_i | input | AW | Physical base added to CPU addresses, sampled at acceptance |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle and able to take a command |
| cmd_funct3_i | input | F3W | Function code of the custom instruction |
| cmd_addr_i | input | AW | CPU-side start byte address of the array |
| cmd_len_i | input | DW | Element count |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DW | Sum or error word, valid with done_o |
| req_valid_o | output | 1 | Load request valid (FIFO push) |
| req_ready_i | input | 1 | Request FIFO not full |
| req_addr_o | output | AW | Physical word address of the load |
| rsp_valid_i | input | 1 | Response FIFO not empty |
| rsp_ready_o | output | 1 | Response pop |
| rsp_data_i | input | DW | Loaded word |

## Verification
A corrupted element or remaining-count register shows up as a wrong sum, or as a wrong request count at the bridge, at the end of the same command. An address register that is off shows up at the very first misplaced request, because each request address is compared with the expected sequence as it is issued. A wrong in-flight count shows within the next long-latency burst, either as a fifth outstanding request or as a pop with nothing pending. A broken command check shows one cycle after acceptance, as a wrong error word or as a request where none may appear.

// File: rtl/acc_sum_pkg.sv
package acc_sum_pkg;
  localparam logic [31:0] RES_UNSUP  = 32'hFFFF_FFFE;
  localparam logic [31:0] RES_BADARG = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} acc_state_e;
  typedef enum logic [1:0] {CK_GO, CK_EMPTY, CK_UNSUP, CK_BADARG} chk_e;
endpackage

// File: rtl/acc_cmd_check.sv
module acc_cmd_check
  import acc_sum_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int F3W = 3
) (
  input  logic [F3W-1:0] funct3_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  len_i,
  output chk_e           verdict_o
);
  localparam int ALIGN_BITS = $clog2(DW / 8);

  // function code outranks alignment, alignment outranks empty length
  always_comb begin
    if (funct3_i != '0)                       verdict_o = CK_UNSUP;
    else if (addr_i[ALIGN_BITS-1:0] != '0)    verdict_o = CK_BADARG;
    else if (len_i == '0)                     verdict_o = CK_EMPTY;
    else                                      verdict_o = CK_GO;
  end
endmodule

// File: rtl/acc_req_issuer.sv
module acc_req_issuer #(
  parameter int AW      = 32,
  parameter int CW      = 32,
  parameter int STEP    = 4,
  parameter int MAX_OUT = 4,
  parameter int OW      = $clog2(MAX_OUT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] count_i,
  input  logic          rsp_fire_i,
  input  logic          req_ready_i,
  output logic          req_valid_o,
  output logic [AW-1:0] req_addr_o,
  output logic [OW-1:0] outst_o
);
  logic [AW-1:0] next_addr_q;
  logic [CW-1:0] left_q;
  logic [OW-1:0] outst_q;
  logic          req_fire;

  assign req_valid_o = (left_q != '0) && (outst_q < OW'(MAX_OUT));
  assign req_addr_o  = next_addr_q;
  assign outst_o     = outst_q;
  assign req_fire    = req_valid_o && req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_addr_q <= '0;
      left_q      <= '0;
    end else if (start_i) begin
      next_addr_q <= base_i + addr_i;
      left_q      <= count_i;
    end else if (req_fire) begin
      next_addr_q <= next_addr_q + AW'(STEP);
      left_q      <= left_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= '0;
    else         outst_q <= outst_q + OW'(req_fire) - OW'(rsp_fire_i);
  end

  AST_OUTST_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q <= OW'(MAX_OUT)); // R6
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o)); // R6
  AST_NO_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fire_i |-> outst_q != '0); // R6
endmodule

// File: rtl/acc_rsp_accum.sv
module acc_rsp_accum #(
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic          rsp_fire_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic [DW-1:0] sum_next_o,
  output logic          last_o
);
  logic [DW-1:0] sum_q;
  logic [CW-1:0] left_q;

  assign sum_next_o = sum_q + rsp_data_i;  // wraps mod 2^DW
  assign last_o     = rsp_fire_i && (left_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      left_q <= '0;
    end else if (start_i) begin
      sum_q  <= '0;
      left_q <= count_i;
    end else if (rsp_fire_i) begin
      sum_q  <= sum_next_o;
      left_q <= left_q - CW'(1);
    end
  end

  AST_RSP_EXPECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fire_i |-> left_q != '0); // R1
endmodule

// File: rtl/acc_sum_unit.sv
module acc_sum_unit
  import acc_sum_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int F3W     = 3,
  parameter int MAX_OUT = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  base_addr_i,
  input  logic           cmd_valid_i,
  output logic           cmd_ready_o,
  input  logic [F3W-1:0] cmd_funct3_i,
  input  logic [AW-1:0]  cmd_addr_i,
  input  logic [DW-1:0]  cmd_len_i,
  output logic           done_o,
  output logic [DW-1:0]  result_o,
  output logic           req_valid_o,
  input  logic           req_ready_i,
  output logic [AW-1:0]  req_addr_o,
  input  logic           rsp_valid_i,
  output logic           rsp_ready_o,
  input  logic [DW-1:0]  rsp_data_i
);
  localparam int CW   = DW;
  localparam int STEP = DW / 8;
  localparam int OW   = $clog2(MAX_OUT + 1);

  acc_state_e    state_q;
  logic [DW-1:0] result_q;
  chk_e          verdict;
  logic [OW-1:0] outst;
  logic [DW-1:0] sum_next;
  logic          last_rsp;
  logic          cmd_fire;
  logic          start_run;
  logic          rsp_fire;

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign start_run   = cmd_fire && (verdict == CK_GO);
  assign rsp_ready_o = (state_q == ST_RUN) && (outst != '0);
  assign rsp_fire    = rsp_ready_o && rsp_valid_i;
  assign done_o      = (state_q == ST_DONE);
  assign result_o    = result_q;

  acc_cmd_check #(.AW(AW), .DW(DW), .F3W(F3W)) u_check (
    .funct3_i (cmd_funct3_i),
    .addr_i   (cmd_addr_i),
    .len_i    (cmd_len_i),
    .verdict_o(verdict)
  );

  acc_req_issuer #(.AW(AW), .CW(CW), .STEP(STEP), .MAX_OUT(MAX_OUT), .OW(OW)) u_bridge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_run),
    .base_i     (base_addr_i),
    .addr_i     (cmd_addr_i),
    .count_i    (cmd_len_i),
    .rsp_fire_i (rsp_fire),
    .req_ready_i(req_ready_i),
    .req_valid_o(req_valid_o),
    .req_addr_o (req_addr_o),
    .outst_o    (outst)
  );

  acc_rsp_accum #(.DW(DW), .CW(CW)) u_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_run),
    .count_i   (cmd_len_i),
    .rsp_fire_i(rsp_fire),
    .rsp_data_i(rsp_data_i),
    .sum_next_o(sum_next),
    .last_o    (last_rsp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      result_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_fire) begin
          unique case (verdict)
            CK_GO:     state_q <= ST_RUN;
            CK_EMPTY:  begin state_q <= ST_DONE; result_q <= '0; end
            CK_UNSUP:  begin state_q <= ST_DONE; result_q <= DW'(RES_UNSUP); end
            CK_BADARG: begin state_q <= ST_DONE; result_q <= DW'(RES_BADARG); end
            default:   state_q <= ST_IDLE;
          endcase
        end
        ST_RUN: if (last_rsp) begin
          state_q  <= ST_DONE;
          result_q <= sum_next;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_NO_REQ_OUTSIDE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN) |-> !req_valid_o); // R2 R3 R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_fire |=> !cmd_ready_o); // R7
  AST_DONE_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (outst == '0) && !req_valid_o); // R6
endmodule

// File: tb/acc_sum_unit_tb_top.sv
module acc_sum_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_OUT    = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic [2:0]  cmd_funct3_i = '0;
  logic [31:0] cmd_addr_i = '0;
  logic [31:0] cmd_len_i = '0;
  logic        done_o;
  logic [31:0] result_o;
  logic        req_valid_o;
  logic        req_ready_i = 1'b0;
  logic [31:0] req_addr_o;
  logic        rsp_valid_i = 1'b0;
  logic        rsp_ready_o;
  logic [31:0] rsp_data_i = '0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  acc_sum_unit #(.MAX_OUT(MAX_OUT)) dut_i (
    .clk_i, .rst_ni, .base_addr_i, .cmd_valid_i, .cmd_ready_o, .cmd_funct3_i,
    .cmd_addr_i, .cmd_len_i, .done_o, .result_o, .req_valid_o, .req_ready_i,
    .req_addr_o, .rsp_valid_i, .rsp_ready_o, .rsp_data_i
  );

  int n_checks = 0;
  int n_err    = 0;

  // memory model state
  int unsigned ready_pct = 100;
  int unsigned lat_min = 1, lat_max = 1;
  int unsigned cyc = 0;
  logic [31:0] pend_addr[$];
  int unsigned pend_due[$];
  logic [31:0] exp_addr;
  int unsigned req_cnt, addr_err, max_out, hold_err, pop_err;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ {a[15:0], a[31:16]} ^ 32'hC001_D00D;
  endfunction

  function automatic logic [31:0] exp_sum(logic [31:0] phys, logic [31:0] n);
    logic [31:0] s = '0;
    for (int i = 0; i < int'(n); i++) s += mem_word(phys + 32'(4 * i));
    return s;
  endfunction

  task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", what, act, expv);
    end
  endtask

  // request/response FIFO model
  initial begin
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin
        pend_addr.delete(); pend_due.delete();
        req_ready_i = 1'b0; rsp_valid_i = 1'b0; prev_stall = 1'b0;
      end else begin
        if (prev_stall && (!req_valid_o || req_addr_o != prev_addr)) hold_err++;
        req_ready_i = ($urandom_range(99) < ready_pct);
        if (pend_addr.size() != 0 && pend_due[0] <= cyc) begin
          rsp_valid_i = 1'b1; rsp_data_i = mem_word(pend_addr[0]);
        end else begin
          rsp_valid_i = 1'b0; rsp_data_i = $urandom;
        end
        #1;
        if (rsp_ready_o && pend_addr.size() == 0) pop_err++;
        prev_stall = req_valid_o && !req_ready_i;
        prev_addr  = req_addr_o;
        if (req_valid_o && req_ready_i) begin
          pend_addr.push_back(req_addr_o);
          pend_due.push_back(cyc + 1 + $urandom_range(lat_max, lat_min));
          req_cnt++;
          if (req_addr_o != exp_addr) addr_err++;
          exp_addr += 32'd4;
        end
        if (rsp_valid_i && rsp_ready_o) begin
          void'(pend_addr.pop_front()); void'(pend_due.pop_front());
        end
        if (pend_addr.size() > max_out) max_out = pend_addr.size();
        cyc++;
      end
    end
  end

  logic [31:0] got_res;
  int          got_lat;

  task automatic run_cmd(input logic [2:0] f3, input logic [31:0] addr,
                         input logic [31:0] len, input logic [31:0] base, input string tag);
    int guard = 0;
    int busy_err = 0;
    @(negedge clk_i);
    while (!cmd_ready_o && guard < 5000) begin @(negedge clk_i); guard++; end
    base_addr_i = base; cmd_funct3_i = f3; cmd_addr_i = addr; cmd_len_i = len;
    req_cnt = 0; addr_err = 0; max_out = 0; hold_err = 0; pop_err = 0;
    exp_addr = base + addr;
    cmd_valid_i = 1'b1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    base_addr_i = $urandom; cmd_addr_i = $urandom; cmd_len_i = $urandom; cmd_funct3_i = 3'($urandom);
    got_lat = 1;
    while (!done_o && got_lat < 5000) begin
      if (cmd_ready_o) busy_err++;
      @(negedge clk_i); got_lat++;
    end
    got_res = result_o;
    check(done_o == 1'b1, {tag, " R7 done seen"}, 32'(done_o), 32'd1);
    check(busy_err == 0, {tag, " R7 ready low while busy"}, busy_err, 0);
    @(negedge clk_i);
    check(done_o == 1'b0 && cmd_ready_o == 1'b1, {tag, " R7 done one-cycle pulse"},
          {30'd0, done_o, cmd_ready_o}, 32'd1);
  endtask

  task automatic run_sum(logic [31:0] addr, logic [31:0] len, logic [31:0] base, string tag);
    run_cmd(3'd0, addr, len, base, tag);
    check(got_res == exp_sum(base + addr, len), {tag, " R1 sum"}, got_res, exp_sum(base + addr, len));
    check(req_cnt == len, {tag, " R5 request count"}, req_cnt, len);
    check(addr_err == 0, {tag, " R5 request addresses"}, addr_err, 0);
    check(max_out <= MAX_OUT && hold_err == 0 && pop_err == 0, {tag, " R6 flow control"},
          {max_out[15:0], hold_err[7:0], pop_err[7:0]}, 32'd0 | MAX_OUT << 16);
  endtask

  task automatic run_quick(logic [2:0] f3, logic [31:0] addr, logic [31:0] len,
                           logic [31:0] expv, string tag);
    run_cmd(f3, addr, len, 32'h8000_0000, tag);
    check(got_res == expv, {tag, " result word"}, got_res, expv);
    check(got_lat == 1, {tag, " done one cycle after accept"}, got_lat, 1);
    check(req_cnt == 0, {tag, " no memory traffic"}, req_cnt, 0);
  endtask

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk_i);
    // R8 reset state
    check(cmd_ready_o == 1'b1, "R8 reset cmd_ready_o", 32'(cmd_ready_o), 32'd1);
    check(done_o == 1'b0, "R8 reset done_o", 32'(done_o), 32'd0);
    check(req_valid_o == 1'b0 && rsp_ready_o == 1'b0, "R8 reset bridge idle",
          {30'd0, req_valid_o, rsp_ready_o}, 32'd0);
    rst_ni = 1'b1;

    run_sum(32'h0000_4000, 32'd8, 32'h8000_0000, "base array");
    run_sum(32'h0000_6000, 32'd8, 32'h8000_0000, "alt array R5");
    run_sum(32'h0000_4000, 32'd8, 32'h1000_0000, "alt base R5");
    run_quick(3'd3, 32'h0000_4002, 32'd5, 32'hFFFF_FFFE, "R2 unsupported over misaligned");
    run_quick(3'd7, 32'h0000_4000, 32'd5, 32'hFFFF_FFFE, "R2 unsupported");
    run_quick(3'd0, 32'h0000_4002, 32'd5, 32'hFFFF_FFFF, "R3 misaligned by 2");
    run_quick(3'd0, 32'h0000_4001, 32'd0, 32'hFFFF_FFFF, "R3 misaligned by 1");
    run_quick(3'd0, 32'h0000_4000, 32'd0, 32'h0000_0000, "R4 empty length");

    // R6: slow memory fills the in-flight window
    lat_min = 12; lat_max = 16; ready_pct = 100;
    run_sum(32'h0000_5000, 32'd20, 32'h8000_0000, "R6 slow memory");
    check(max_out == MAX_OUT, "R6 window reaches limit", max_out, MAX_OUT);
    // backpressure on requests
    lat_min = 1; lat_max = 3; ready_pct = 30;
    run_sum(32'h0000_7000, 32'd25, 32'h8000_0000, "R6 request stall");

    // R7 back to back, independent results in order
    ready_pct = 70; lat_min = 1; lat_max = 6;
    run_sum(32'h0000_4000, 32'd6, 32'h8000_0000, "R7 first of pair");
    run_sum(32'h0000_4100, 32'd9, 32'h8000_0000, "R7 second of pair");

    // constrained random mix
    for (int k = 0; k < 40; k++) begin
      logic [2:0]  f3   = ($urandom_range(9) == 0) ? 3'($urandom_range(7, 1)) : 3'd0;
      logic [31:0] addr = {16'd0, 14'($urandom), 2'b00};
      logic [31:0] len  = $urandom_range(40);
      logic [31:0] base = $urandom;
      if ($urandom_range(9) == 0) addr[1:0] = 2'($urandom_range(3, 1));
      ready_pct = $urandom_range(100, 20); lat_min = $urandom_range(4);
      lat_max = lat_min + $urandom_range(10);
      if (f3 != 0)           run_quick(f3, addr, len, 32'hFFFF_FFFE, "R2 random");
      else if (addr[1:0] != 0) run_quick(f3, addr, len, 32'hFFFF_FFFF, "R3 random");
      else if (len == 0)      run_quick(f3, addr, len, 32'h0, "R4 random");
      else                    run_sum(addr, len, base, "R1 random");
    end

    // R8 reset in the middle of a long command
    lat_min = 5; lat_max = 9; ready_pct = 100;
    @(negedge clk_i);
    base_addr_i = 32'h8000_0000; cmd_funct3_i = 3'd0; cmd_addr_i = 32'h4000; cmd_len_i = 32'd50;
    exp_addr = 32'h8000_4000;
    cmd_valid_i = 1'b1;
    @(negedge clk_i); cmd_valid_i = 1'b0;
    repeat (10) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(cmd_ready_o == 1'b1 && done_o == 1'b0 && req_valid_o == 1'b0 && rsp_ready_o == 1'b0,
          "R8 mid-run reset idle", {28'd0, cmd_ready_o, done_o, req_valid_o, rsp_ready_o}, 32'h8);
    @(negedge clk_i); rst_ni = 1'b1;
    run_sum(32'h0000_4000, 32'd12, 32'h8000_0000, "R8 after reset");

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_err++;
    $display("FAIL R7 watchdog expired act=%0d exp=0", 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule